// File: doc/BRIEF.md
# Capacitor Trim Word Write Sequencer

This block runs on the programmer side of a digitally trimmed tuning capacitor. The capacitor holds an 11-bit trim word in non-volatile cells, reached over three lines: a serial data line, a serial clock and a programming-voltage strobe. A host hands the sequencer a target trim word and a start pulse. The sequencer then brings the stored word to that target. An optional erase cycle comes first. After that it reads back each stored bit. It inverts the target, because a stored zero switches a capacitor in, and compares the two words. For every mismatched bit it runs one program cycle. It finishes with a second full readback that decides pass or fail.

Every serial frame carries 11 bits, lowest bit first, each taken on a rising edge of the serial clock. A readback or program frame is all ones except for a zero at the one bit position it addresses. An erase frame is all ones. After a program or erase frame, the strobe enable goes high for a set number of cycles and then stays low for an idle time. The serial clock and data line do not move during the strobe. After a readback frame both lines stay high while the returned sense level is sampled. The pulse and idle lengths are parameters, so short values can be used on a test bench.

Top module: `cap_word_writer`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o, pass_o, fail_o, pv_en_o, sclk_o and sda_o are low and diff_cnt_o is zero.
- R2: Each frame gives exactly 11 rising edges on sclk_o. Word bit 0 is on sda_o at the first rising edge and bit 10 at the last. After the last edge, sclk_o and sda_o both stay high until the next frame starts.
- R3: A readback of bit i sends a frame with a zero only at position i and then samples sense_i. A high sense level means the stored bit i is 1.
- R4: diff_cnt_o equals the number of positions 10 down to 1 where the first readback differs from the inverted target. Bit 0 is a check bit and is never counted.
- R5: Each counted position gets exactly one program cycle, whose frame has a zero only at that position. Positions that already match get none. Without erase, the strobe pulses once per counted bit.
- R6: Each strobe pulse lasts exactly PULSE_CYC cycles. sclk_o and sda_o stay high and unchanged during it, and sclk_o stays high for at least GAP_CYC cycles after it.
- R7: When erase_i is high at an accepted start, an all-ones frame and one strobe pulse come before the first readback. The comparison then uses the erased contents.
- R8: The operation ends with a full readback. pass_o is set when bits 10 down to 1 of that readback equal the inverted target, otherwise fail_o is set. Exactly one of them is high once done_o rises.
- R9: target_i and erase_i are sampled only when start_i is accepted in the idle or done state. start_i while busy_o is high has no effect.
- R10: done_o rises when the verify readback completes, with busy_o low. done_o, pass_o, fail_o and diff_cnt_o hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, accepted when not busy |
| erase_i | input | 1 | Erase before readback, sampled with start |
| target_i | input | 11 | Requested trim word, 1 = capacitor in |
| sense_i | input | 1 | Returned level of the strobe line during readback |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished, held until next start |
| pass_o | output | 1 | Verify readback matches target |
| fail_o | output | 1 | Verify readback differs from target |
| diff_cnt_o | output | 4 | Number of differing bits found in the first readback |
| sclk_o | output | 1 | Serial clock to the device |
| sda_o | output | 1 | Serial data to the device |
| pv_en_o | output | 1 | Enables the external programming-voltage driver |

## Verification
The assertions assume that start pulses never overlap the internal frame shifter, that the pulse and gap timers are loaded only when they have run out, and that the parameters PULSE_CYC and GAP_CYC are at least 1. The bench drives sense_i from a behavioural model of the device. The model shifts on sclk_o, clears the addressed cell on a strobe, sets every cell on an all-ones strobe, and answers a readback only while both lines are high. sense_i therefore changes only at points the sequencer allows. The stimulus mixes random stored words, targets and erase requests with directed cases: the two-bit example, an already-matching word, a word that cannot be reached without erase, and a start issued while busy.

// File: rtl/cww_pkg.sv
package cww_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_SAMPLE,
    ST_PULSE,
    ST_GAP,
    ST_CMP,
    ST_SCAN,
    ST_DONE
  } seq_state_t;

  typedef enum logic {
    FR_READ,
    FR_PROG
  } frame_kind_t;

  function automatic logic [5:0] ones_in(input logic [31:0] v);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + {5'd0, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/cww_shifter.sv
module cww_shifter #(
  parameter int unsigned WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sclk_o,
  output logic              sda_o,
  output logic              fin_o,
  output logic              active_o
);
  localparam int unsigned IDX_W = $clog2(WORD_W);

  logic              act_q, act_n, ph_q, ph_n, sclk_q, sclk_n, sda_q, sda_n, fin_q, fin_n;
  logic [IDX_W-1:0]  idx_q, idx_n, idx_nx;
  logic [WORD_W-1:0] sh_q, sh_n;

  assign idx_nx = idx_q + 1'b1;

  always_comb begin
    act_n  = act_q;
    ph_n   = ph_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    sclk_n = sclk_q;
    sda_n  = sda_q;
    fin_n  = 1'b0;
    if (!act_q) begin
      if (go_i) begin
        act_n  = 1'b1;
        ph_n   = 1'b0;
        idx_n  = '0;
        sh_n   = word_i;
        sclk_n = 1'b0;
        sda_n  = word_i[0];
      end
    end else if (!ph_q) begin
      sclk_n = 1'b1;
      ph_n   = 1'b1;
    end else if (idx_q == IDX_W'(WORD_W-1)) begin
      act_n = 1'b0;
      fin_n = 1'b1;
      sda_n = 1'b1;
    end else begin
      idx_n  = idx_nx;
      ph_n   = 1'b0;
      sclk_n = 1'b0;
      sda_n  = sh_q[idx_nx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b0;
      sda_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      act_q  <= act_n;
      ph_q   <= ph_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      sclk_q <= sclk_n;
      sda_q  <= sda_n;
      fin_q  <= fin_n;
    end
  end

  assign sclk_o   = sclk_q;
  assign sda_o    = sda_q;
  assign fin_o    = fin_q;
  assign active_o = act_q;

  // R2: a new frame is only requested while no frame is running
  assert_go_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !act_q);
  // R2: the frame ends with both lines high
  assert_fin_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (sclk_q && sda_q && !act_q));

endmodule

// File: rtl/cww_timer.sv
module cww_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (load_i)              cnt_n = len_i;
    else if (cnt_q != '0)    cnt_n = cnt_q - 1'b1;
    else                     cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign fire_o = (cnt_q == CNT_W'(1));

  // R6: the timer is reloaded only once it has run out or is on its last cycle
  assert_load_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (cnt_q <= CNT_W'(1)));

endmodule

// File: rtl/cap_word_writer.sv
module cap_word_writer
  import cww_pkg::*;
#(
  parameter int unsigned WORD_W    = 11,
  parameter int unsigned PULSE_CYC = 500000,
  parameter int unsigned GAP_CYC   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [WORD_W-1:0] target_i,
  input  logic              sense_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [$clog2(WORD_W+1)-1:0] diff_cnt_o,
  output logic              sclk_o,
  output logic              sda_o,
  output logic              pv_en_o
);
  localparam int unsigned IX_W   = $clog2(WORD_W+1);
  localparam int unsigned CNT_W  = $clog2(WORD_W+1);
  localparam int unsigned TM_MAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int unsigned TM_W   = $clog2(TM_MAX+1);
  localparam logic [WORD_W-1:0] CHK_MASK = ~WORD_W'(1);

  function automatic logic [WORD_W-1:0] sel_word(input logic [IX_W-1:0] i);
    return ~({{(WORD_W-1){1'b0}}, 1'b1} << i);
  endfunction

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  seq_state_t        st_q, st_n;
  frame_kind_t       kind_q, kind_n;
  logic [IX_W-1:0]   idx_q, idx_n;
  logic [WORD_W-1:0] tgt_q, tgt_n, rd_q, rd_n, dif_q, dif_n, dv_w, fword;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic ers_q, ers_n, ver_q, ver_n, pv_q, pv_n;
  logic done_q, done_n, pass_q, pass_n, fail_q, fail_n;
  logic go, fin, sh_act, tload, tfire;
  logic [TM_W-1:0] tlen;

  cww_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_sn), .go_i(go), .word_i(fword),
    .sclk_o(sclk_o), .sda_o(sda_o), .fin_o(fin), .active_o(sh_act)
  );

  cww_timer #(.CNT_W(TM_W)) u_timer (
    .clk(clk), .rst_n(rst_sn), .load_i(tload), .len_i(tlen), .fire_o(tfire)
  );

  assign dv_w = (rd_q ^ ~tgt_q) & CHK_MASK;

  always_comb begin
    st_n = st_q;  kind_n = kind_q;  idx_n = idx_q;  tgt_n = tgt_q;
    rd_n = rd_q;  dif_n = dif_q;    cnt_n = cnt_q;  ers_n = ers_q;
    ver_n = ver_q; pv_n = pv_q;     done_n = done_q;
    pass_n = pass_q; fail_n = fail_q;
    go = 1'b0;  fword = '1;  tload = 1'b0;  tlen = TM_W'(PULSE_CYC);
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          tgt_n = target_i;  done_n = 1'b0;  pass_n = 1'b0;  fail_n = 1'b0;
          cnt_n = '0;  ver_n = 1'b0;  idx_n = '0;  go = 1'b1;  st_n = ST_SHIFT;
          if (erase_i) begin
            kind_n = FR_PROG;  ers_n = 1'b1;  fword = '1;
          end else begin
            kind_n = FR_READ;  ers_n = 1'b0;  fword = sel_word('0);
          end
        end
      end
      ST_SHIFT: begin
        if (fin) begin
          if (kind_q == FR_READ) st_n = ST_SAMPLE;
          else begin
            st_n = ST_PULSE;  pv_n = 1'b1;  tload = 1'b1;
          end
        end
      end
      ST_SAMPLE: begin
        rd_n[idx_q] = sense_i;
        if (idx_q == IX_W'(WORD_W-1)) begin
          if (ver_q) begin
            pass_n = (((rd_n ^ ~tgt_q) & CHK_MASK) == '0);
            fail_n = !pass_n;
            done_n = 1'b1;
            st_n   = ST_DONE;
          end else st_n = ST_CMP;
        end else begin
          idx_n = idx_q + 1'b1;  go = 1'b1;  fword = sel_word(idx_n);  st_n = ST_SHIFT;
        end
      end
      ST_PULSE: begin
        if (tfire) begin
          pv_n = 1'b0;  tload = 1'b1;  tlen = TM_W'(GAP_CYC);  st_n = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tfire) begin
          if (ers_q) begin
            ers_n = 1'b0;  kind_n = FR_READ;  idx_n = '0;
            go = 1'b1;  fword = sel_word('0);  st_n = ST_SHIFT;
          end else begin
            idx_n = idx_q + 1'b1;  st_n = ST_SCAN;
          end
        end
      end
      ST_CMP: begin
        dif_n = dv_w;
        cnt_n = CNT_W'(ones_in(32'(dv_w)));
        idx_n = IX_W'(1);
        st_n  = ST_SCAN;
      end
      ST_SCAN: begin
        if (idx_q == IX_W'(WORD_W)) begin
          ver_n = 1'b1;  kind_n = FR_READ;  idx_n = '0;
          go = 1'b1;  fword = sel_word('0);  st_n = ST_SHIFT;
        end else if (dif_q[idx_q]) begin
          kind_n = FR_PROG;  go = 1'b1;  fword = sel_word(idx_q);  st_n = ST_SHIFT;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q <= ST_IDLE;  kind_q <= FR_READ;  idx_q <= '0;  tgt_q <= '0;
      rd_q <= '0;  dif_q <= '0;  cnt_q <= '0;  ers_q <= 1'b0;  ver_q <= 1'b0;
      pv_q <= 1'b0;  done_q <= 1'b0;  pass_q <= 1'b0;  fail_q <= 1'b0;
    end else begin
      st_q <= st_n;  kind_q <= kind_n;  idx_q <= idx_n;  tgt_q <= tgt_n;
      rd_q <= rd_n;  dif_q <= dif_n;  cnt_q <= cnt_n;  ers_q <= ers_n;  ver_q <= ver_n;
      pv_q <= pv_n;  done_q <= done_n;  pass_q <= pass_n;  fail_q <= fail_n;
    end
  end

  assign busy_o     = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign fail_o     = fail_q;
  assign diff_cnt_o = cnt_q;
  assign pv_en_o    = pv_q;

  // strobe length checker counter
  logic [TM_W-1:0] pw_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)   pw_q <= '0;
    else if (pv_q) pw_q <= pw_q + 1'b1;
    else           pw_q <= '0;
  end

  // R6: serial lines idle high and still while the strobe is on
  assert_pv_still_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    pv_en_o |-> (sclk_o && sda_o && $stable(sclk_o) && !sh_act));
  // R6: strobe lasts exactly PULSE_CYC cycles
  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(pv_en_o) |-> (pw_q == TM_W'(PULSE_CYC)));
  // R8: verdict flags are exclusive and one is set at completion
  assert_verdict_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |-> (pass_o ^ fail_o));
  // R10: never busy and done together
  assert_busy_done_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !(busy_o && done_o));
  // R9: the captured target does not move while busy
  assert_hold_target_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    busy_o |=> $stable(tgt_q));
  // R4: the count never includes the check bit
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    diff_cnt_o <= CNT_W'(WORD_W-1));

endmodule

// File: tb/test_cap_word_writer.sv
module test_cap_word_writer;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 11;
  localparam int PULSE = 20;
  localparam int GAP   = 6;
  localparam int OP_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, erase_i = 1'b0;
  logic [W-1:0] target_i = '0;
  logic sense_i;
  logic busy_o, done_o, pass_o, fail_o, sclk_o, sda_o, pv_en_o;
  logic [3:0] diff_cnt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_word_writer #(.WORD_W(W), .PULSE_CYC(PULSE), .GAP_CYC(GAP)) i_cap_word_writer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
    .target_i(target_i), .sense_i(sense_i), .busy_o(busy_o), .done_o(done_o),
    .pass_o(pass_o), .fail_o(fail_o), .diff_cnt_o(diff_cnt_o),
    .sclk_o(sclk_o), .sda_o(sda_o), .pv_en_o(pv_en_o)
  );

  // behavioural device model
  logic [W-1:0] dev_sh = '1;
  logic [W-1:0] dev_mem = '1;
  logic [W-1:0] mem_val = '1;
  logic mem_ld = 1'b0;
  always @(posedge sclk_o) dev_sh <= {sda_o, dev_sh[W-1:1]};
  always @(posedge pv_en_o or posedge mem_ld) begin
    if (mem_ld)        dev_mem <= mem_val;
    else if (&dev_sh)  dev_mem <= '1;
    else               dev_mem <= dev_mem & dev_sh;
  end
  always_comb begin
    sense_i = 1'b0;
    if (sda_o && sclk_o && ($countones(~dev_sh) == 1))
      for (int i = 0; i < W; i++) if (!dev_sh[i]) sense_i = dev_mem[i];
  end

  // edge and timing monitors
  int pv_rises = 0, sclk_rises = 0;
  int pw_run = 0, pw_bad = 0, gap_bad = 0, still_bad = 0, g_cnt = 0;
  bit g_arm = 0, pv_prev = 0;
  always @(posedge pv_en_o) pv_rises++;
  always @(posedge sclk_o) sclk_rises++;
  always @(negedge clk) begin
    if (pv_en_o) begin
      pw_run++;
      if (!sclk_o || !sda_o) still_bad++;
    end else begin
      if (pw_run != 0 && pw_run != PULSE) pw_bad++;
      pw_run = 0;
    end
    if (pv_prev && !pv_en_o) begin
      g_arm = 1; g_cnt = 0;
    end else if (g_arm) begin
      if (sclk_o) g_cnt++;
      else begin
        if (g_cnt + 1 < GAP) gap_bad++;
        g_arm = 0;
      end
    end
    pv_prev = pv_en_o;
  end

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pop(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic run_op(input logic [W-1:0] mem0, input logic [W-1:0] tgt,
                        input bit ers, input bit poke);
    logic [W-1:0] base, dif, fin_mem;
    int ecnt, p0, s0, pb0, gb0, sb0, cyc;
    bit epass;
    base    = ers ? '1 : mem0;
    dif     = (base ^ ~tgt) & ~W'(1);
    ecnt    = pop(dif);
    fin_mem = base & ~dif;
    epass   = (((fin_mem ^ ~tgt) & ~W'(1)) == '0);

    @(negedge clk); mem_val = mem0; mem_ld = 1'b1;
    @(negedge clk); mem_ld = 1'b0;
    p0 = pv_rises; s0 = sclk_rises; pb0 = pw_bad; gb0 = gap_bad; sb0 = still_bad;
    target_i = tgt; erase_i = ers; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    target_i = W'($urandom); erase_i = 1'(~ers);  // R9: changes after start are ignored
    check(busy_o && !done_o, "R10", "busy after start", int'(busy_o), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      target_i = ~tgt; erase_i = 1'(~ers); start_i = 1'b1;  // R9: start while busy
      @(negedge clk); start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < OP_LIMIT) begin
      @(negedge clk); cyc++;
    end
    check(done_o == 1'b1, "R10", "operation finished before watchdog", int'(done_o), 1);
    check(!busy_o, "R10", "busy low at done", int'(busy_o), 0);
    check(int'(diff_cnt_o) == ecnt, "R4", "difference count", int'(diff_cnt_o), ecnt);
    check((pv_rises - p0) == ecnt + int'(ers), "R5", "strobe pulses (R7 erase adds one)",
          pv_rises - p0, ecnt + int'(ers));
    check((sclk_rises - s0) == W * (2*W + ecnt + int'(ers)), "R2", "clock edges",
          sclk_rises - s0, W * (2*W + ecnt + int'(ers)));
    check(dev_mem == fin_mem, "R3", "stored word after writes", int'(dev_mem), int'(fin_mem));
    check(pass_o == epass && fail_o == !epass, "R8", "pass flag", int'(pass_o), int'(epass));
    check(pw_bad == pb0 && still_bad == sb0, "R6", "strobe length and still lines",
          pw_bad - pb0 + still_bad - sb0, 0);
    check(gap_bad == gb0, "R6", "idle after strobe", gap_bad - gb0, 0);
    repeat (3) @(negedge clk);
    check(done_o && int'(diff_cnt_o) == ecnt, "R10", "results held", int'(done_o), 1);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = int'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check({busy_o, done_o, pass_o, fail_o, pv_en_o, sclk_o, sda_o} == '0 && diff_cnt_o == 0,
          "R1", "outputs in reset", int'({busy_o, done_o, pv_en_o, sclk_o, sda_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy_o, done_o, pass_o, fail_o, pv_en_o, sclk_o, sda_o} == '0,
          "R1", "outputs after reset", int'({busy_o, done_o, pv_en_o, sclk_o, sda_o}), 0);

    // R5: two-bit example from an erased store, bit0 of target set (check bit ignored, R4)
    run_op(11'h7FF, 11'b00000010101, 1'b0, 1'b0);
    // R5: already matching, no program cycles
    run_op(~11'b01100110010, 11'b01100110010, 1'b0, 1'b0);
    // R8: unreachable without erase, must fail
    run_op(11'h000, 11'h3F0, 1'b0, 1'b0);
    // R7: same word with erase succeeds
    run_op(11'h000, 11'h3F0, 1'b1, 1'b0);
    // R9: start while busy ignored
    run_op(11'h5A5, 11'h0C3, 1'b1, 1'b1);
    // R7: erase with target all zeros: no program cycles after erase
    run_op(11'h123, 11'h000, 1'b1, 1'b0);
    // R4: all ten counted bits differ
    run_op(11'h7FF, 11'h7FE, 1'b0, 1'b0);

    for (int k = 0; k < 30; k++)
      run_op(W'($urandom), W'($urandom), 1'($urandom), 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule